// File: doc/BRIEF.md
# Dual-Edge I/Q Transmit Demultiplexer

This block takes one 8-bit transmit bus that carries in-phase and quadrature samples in alternation, one word per clock edge. The word present at each rising edge goes into the in-phase code register, and the word present at each falling edge goes into the quadrature code register. Both registers feed DAC code inputs downstream. Q always lands half a clock after its I partner. The block keeps that half-cycle offset and does not correct it.

A three-state path controller selects what is live. The states are `ST_OFF`, `ST_CDMA` and `ST_FM`.

- In `ST_CDMA`, both paths capture.
- In `ST_FM`, only the quadrature register follows the bus. The in-phase path is parked at mid-scale with its enable low.
- In `ST_OFF`, both paths are parked.

The controller changes state only at rising edges. The transitions are:

- `OFF->CDMA`, `FM->CDMA`: power-down low and FM select low.
- `OFF->FM`, `CDMA->FM`: power-down low and FM select high.
- `CDMA->OFF`, `FM->OFF`: power-down high, whatever the FM select is.
- Self-loops otherwise.

Reset forces `ST_OFF`.

Top module: `txdm_iq_demux`

## Requirements
- R1: A synchronous reset, sampled at either clock edge, sets both codes to mid-scale 0x80. At the next rising edge it leaves both enables low, the pair strobe low, and both park flags high.
- R2: In CDMA operation, `i_code` takes the bus word present at each rising edge, with `txd[7]` as the MSB. `i_code` does not change at falling edges.
- R3: While the quadrature path is enabled, `q_code` takes the bus word present at each falling edge. `q_code` does not change at rising edges.
- R4: The mode changes only at a rising edge. The capture made at that same edge still follows the old mode. Power-down high selects the off state regardless of FM select.
- R5: In FM operation, bus words at rising edges are ignored. `i_code` is held at 0x80, `i_en` is low and `q_en` is high.
- R6: In the off state, both enables are low. `q_code` returns to 0x80 at the first falling edge in that state, and `i_code` returns to 0x80 at the first rising edge in that state.
- R7: `cdma_parked` is high (positive output high, negative output low) whenever the CDMA path is not live. `fm_hiz` is high whenever FM operation is not live. At most one of the two paths is live at a time.
- R8: `pair_vld` is set at a falling edge in CDMA operation when the preceding rising edge captured I. It stays set for one clock period and is low in every other case. After entry into CDMA, the first complete pair uses the I captured at the second rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock; both edges capture |
| rst | input | 1 | Synchronous reset, active high |
| pwr_dn | input | 1 | Power down both transmit paths |
| fm_sel | input | 1 | 1 selects single-path FM operation, 0 selects CDMA |
| txd | input | DATA_W | Interleaved I/Q sample bus |
| i_code | output | DATA_W | In-phase DAC code |
| q_code | output | DATA_W | Quadrature / FM DAC code |
| i_en | output | 1 | In-phase path enable |
| q_en | output | 1 | Quadrature path enable |
| pair_vld | output | 1 | I/Q pair completed at the last falling edge |
| cdma_parked | output | 1 | CDMA outputs parked (positive high, negative low) |
| fm_hiz | output | 1 | FM output in high impedance |

## Verification
A wrong controller state shows at the enables and park flags within a quarter clock of the rising edge that follows the mode request. It also shows as a non-mid-scale `i_code` in FM or off operation. A capture on the wrong edge shows as a code that changes in the wrong half-cycle. The bench therefore samples both codes in each half of every clock period. A wrong pair tracker shows as `pair_vld` high on the first falling edge after entry into CDMA, or in FM operation. It also shows as the strobe staying low in steady CDMA streaming. The bench catches each of these within one clock period.

// File: rtl/txdm_pkg.sv
package txdm_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_CDMA = 2'd1,
        ST_FM   = 2'd2
    } path_state_e;

endpackage

// File: rtl/txdm_mode_fsm.sv
module txdm_mode_fsm
    import txdm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        pwr_dn,
    input  logic        fm_sel,
    output path_state_e state,
    output logic        i_en,
    output logic        q_en,
    output logic        cdma_parked,
    output logic        fm_hiz
);

    path_state_e state_q;
    path_state_e state_d;

    // next-state selection; power-down dominates FM select
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF, ST_CDMA, ST_FM: begin
                if (pwr_dn)      state_d = ST_OFF;
                else if (fm_sel) state_d = ST_FM;
                else             state_d = ST_CDMA;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_OFF;
        else     state_q <= state_d;
    end

    // outputs decoded from the registered state
    always_comb begin
        i_en        = 1'b0;
        q_en        = 1'b0;
        cdma_parked = 1'b1;
        fm_hiz      = 1'b1;
        unique case (state_q)
            ST_CDMA: begin
                i_en        = 1'b1;
                q_en        = 1'b1;
                cdma_parked = 1'b0;
            end
            ST_FM: begin
                q_en   = 1'b1;
                fm_hiz = 1'b0;
            end
            default: ;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/txdm_rise_cap.sv
module txdm_rise_cap
    import txdm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  path_state_e       state,
    input  logic [DATA_W-1:0] txd,
    output logic [DATA_W-1:0] i_code,
    output logic              i_fresh
);

    localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            i_code  <= MID;
            i_fresh <= 1'b0;
        end else begin
            unique case (state)
                ST_CDMA: begin
                    i_code  <= txd;
                    i_fresh <= 1'b1;
                end
                default: begin
                    i_code  <= MID;
                    i_fresh <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/txdm_fall_cap.sv
module txdm_fall_cap
    import txdm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  path_state_e       state,
    input  logic              i_fresh,
    input  logic [DATA_W-1:0] txd,
    output logic [DATA_W-1:0] q_code,
    output logic              pair_vld
);

    localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

    always_ff @(negedge clk) begin
        if (rst) begin
            q_code   <= MID;
            pair_vld <= 1'b0;
        end else begin
            unique case (state)
                ST_CDMA: begin
                    q_code   <= txd;
                    pair_vld <= i_fresh;
                end
                ST_FM: begin
                    q_code   <= txd;
                    pair_vld <= 1'b0;
                end
                default: begin
                    q_code   <= MID;
                    pair_vld <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/txdm_iq_demux.sv
module txdm_iq_demux
    import txdm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_dn,
    input  logic              fm_sel,
    input  logic [DATA_W-1:0] txd,
    output logic [DATA_W-1:0] i_code,
    output logic [DATA_W-1:0] q_code,
    output logic              i_en,
    output logic              q_en,
    output logic              pair_vld,
    output logic              cdma_parked,
    output logic              fm_hiz
);

    path_state_e state;
    logic        i_fresh;

    txdm_mode_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .pwr_dn      (pwr_dn),
        .fm_sel      (fm_sel),
        .state       (state),
        .i_en        (i_en),
        .q_en        (q_en),
        .cdma_parked (cdma_parked),
        .fm_hiz      (fm_hiz)
    );

    txdm_rise_cap #(.DATA_W(DATA_W)) u_rise (
        .clk     (clk),
        .rst     (rst),
        .state   (state),
        .txd     (txd),
        .i_code  (i_code),
        .i_fresh (i_fresh)
    );

    txdm_fall_cap #(.DATA_W(DATA_W)) u_fall (
        .clk      (clk),
        .rst      (rst),
        .state    (state),
        .i_fresh  (i_fresh),
        .txd      (txd),
        .q_code   (q_code),
        .pair_vld (pair_vld)
    );

endmodule

// File: rtl/txdm_iq_demux_chk.sv
module txdm_iq_demux_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              pwr_dn,
    input logic [DATA_W-1:0] txd,
    input logic [DATA_W-1:0] i_code,
    input logic [DATA_W-1:0] q_code,
    input logic              i_en,
    input logic              q_en,
    input logic              pair_vld,
    input logic              cdma_parked,
    input logic              fm_hiz
);

    localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

    a_r1_reset_parks: assert property (@(posedge clk)
        rst |=> (i_code == MID && !i_en && !q_en));

    a_r2_i_follows_rise: assert property (@(posedge clk) disable iff (rst)
        i_en |=> i_code == $past(txd));

    a_r3_q_follows_fall: assert property (@(negedge clk) disable iff (rst)
        q_en |=> q_code == $past(txd));

    a_r4_pwr_dn_wins: assert property (@(posedge clk) disable iff (rst)
        pwr_dn |=> (!q_en && !i_en));

    a_r5_i_idle_mid: assert property (@(posedge clk) disable iff (rst)
        !i_en |=> i_code == MID);

    a_r6_q_off_mid: assert property (@(negedge clk) disable iff (rst)
        !q_en |=> q_code == MID);

    a_r7_one_live_path: assert property (@(posedge clk) disable iff (rst)
        $onehot0({!cdma_parked, !fm_hiz}));

    a_r7_i_needs_q: assert property (@(posedge clk) disable iff (rst)
        i_en |-> q_en);

    a_r8_pair_in_cdma: assert property (@(posedge clk) disable iff (rst)
        pair_vld |-> i_en);

endmodule

bind txdm_iq_demux txdm_iq_demux_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pwr_dn      (pwr_dn),
    .txd         (txd),
    .i_code      (i_code),
    .q_code      (q_code),
    .i_en        (i_en),
    .q_en        (q_en),
    .pair_vld    (pair_vld),
    .cdma_parked (cdma_parked),
    .fm_hiz      (fm_hiz)
);

// File: tb/test_txdm_iq_demux.sv
module test_txdm_iq_demux;

    localparam int CLK_PERIOD = 20;
    localparam logic [7:0] MID = 8'h80;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwr_dn = 1'b0;
    logic       fm_sel = 1'b0;
    logic [7:0] txd = 8'h00;
    logic [7:0] i_code, q_code;
    logic       i_en, q_en, pair_vld, cdma_parked, fm_hiz;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    txdm_iq_demux #(.DATA_W(8)) i_txdm_iq_demux (
        .clk(clk), .rst(rst), .pwr_dn(pwr_dn), .fm_sel(fm_sel), .txd(txd),
        .i_code(i_code), .q_code(q_code), .i_en(i_en), .q_en(q_en),
        .pair_vld(pair_vld), .cdma_parked(cdma_parked), .fm_hiz(fm_hiz)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] iv(input int k);
        return 8'((k * 37 + 5) % 256);
    endfunction

    function automatic logic [7:0] qv(input int k);
        return 8'((k * 91 + 200) % 256);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Called at rising edge + P/4. Drives qw for the falling edge, checks
    // the half-cycle after it, then drives nxt_i for the next rising edge.
    task automatic step(input logic [7:0] qw, input logic [7:0] nxt_i,
                        input logic [7:0] exp_q, input logic [7:0] exp_i_hold,
                        input string tag);
        txd = qw;
        @(negedge clk);
        #(CLK_PERIOD/4);
        chk({tag, " q_code after fall"}, q_code, exp_q);
        chk({tag, " R2 i_code held at fall"}, i_code, exp_i_hold);
        txd = nxt_i;
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        chk("R1 i_code", i_code, MID);
        chk("R1 q_code", q_code, MID);
        chk("R1 i_en", i_en, 0);
        chk("R1 q_en", q_en, 0);
        chk("R1 pair_vld", pair_vld, 0);
        chk("R1 cdma_parked", cdma_parked, 1);
        chk("R1 fm_hiz", fm_hiz, 1);
        rst = 1'b0;
    endtask

    task automatic t_cdma_entry();
        step(8'h11, iv(1), MID, MID, "R6 off");
        chk("R4 i_en after entry", i_en, 1);
        chk("R4 q_en after entry", q_en, 1);
        chk("R7 cdma_parked", cdma_parked, 0);
        chk("R2 no I captured while off", i_code, MID);
        step(qv(1), iv(2), qv(1), MID, "R3 first");
        chk("R2 i_code", i_code, iv(2));
        chk("R8 no pair yet", pair_vld, 0);
    endtask

    task automatic t_cdma_stream();
        for (int k = 2; k < 8; k++) begin
            step(qv(k), iv(k + 1), qv(k), iv(k), "R3 stream");
            chk("R2 i_code stream", i_code, iv(k + 1));
            chk("R8 pair strobe", pair_vld, 1);
        end
        step(8'hFF, 8'h00, 8'hFF, iv(8), "R3 full scale");
        chk("R2 i_code zero", i_code, 8'h00);
        step(8'h00, 8'hFF, 8'h00, 8'h00, "R3 zero");
        chk("R2 i_code full scale", i_code, 8'hFF);
    endtask

    task automatic t_fm();
        fm_sel = 1'b1;
        step(qv(20), 8'hA5, qv(20), 8'hFF, "R3 last cdma");
        chk("R4 capture at switch edge uses old mode", i_code, 8'hA5);
        chk("R5 i_en", i_en, 0);
        chk("R5 q_en", q_en, 1);
        chk("R7 fm_hiz", fm_hiz, 0);
        chk("R7 cdma_parked", cdma_parked, 1);
        for (int k = 21; k < 25; k++) begin
            step(qv(k), 8'h3C, qv(k), (k == 21) ? 8'hA5 : MID, "R3 fm");
            chk("R5 I word ignored", i_code, MID);
            chk("R8 no pair in fm", pair_vld, 0);
        end
    endtask

    task automatic t_off();
        pwr_dn = 1'b1;
        step(qv(30), 8'h77, qv(30), MID, "R3 last fm");
        chk("R4 pwr_dn over fm_sel q_en", q_en, 0);
        chk("R6 i_en", i_en, 0);
        chk("R7 fm_hiz off", fm_hiz, 1);
        chk("R7 cdma_parked off", cdma_parked, 1);
        step(8'h42, 8'h99, MID, MID, "R6 q mid");
        chk("R6 i_code mid", i_code, MID);
    endtask

    task automatic t_reentry();
        pwr_dn = 1'b0;
        fm_sel = 1'b0;
        step(8'h12, iv(40), MID, MID, "R6 still off");
        chk("R4 reentry i_en", i_en, 1);
        step(qv(40), iv(41), qv(40), MID, "R3 reentry");
        chk("R2 reentry i_code", i_code, iv(41));
        chk("R8 first fall after entry", pair_vld, 0);
        step(qv(41), iv(42), qv(41), iv(41), "R3 reentry pair");
        chk("R8 pair after reentry", pair_vld, 1);
    endtask

    task automatic t_midreset();
        rst = 1'b1;
        step(qv(50), iv(50), MID, iv(42), "R1 fall reset");
        chk("R1 mid-run i_code", i_code, MID);
        chk("R1 mid-run i_en", i_en, 0);
        chk("R1 mid-run pair", pair_vld, 0);
        rst = 1'b0;
    endtask

    initial begin
        t_reset();
        t_cdma_entry();
        t_cdma_stream();
        t_fm();
        t_off();
        t_reentry();
        t_midreset();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule